// File: doc/BRIEF.md
# Three-Phase Direct Digital Synthesis Waveform Generator

This block produces three digital waveform channels that share one frequency and are spaced a third of a cycle apart in phase (0, 120 and 240 degrees). A single phase accumulator advances by a tuning increment on every clock. Each channel adds its own fixed offset to the accumulated phase and turns the result into an 8-bit unsigned sample. The shape can be a sine taken from a lookup table, a triangle or a square wave. The samples are meant for an external 8-bit DAC.

The sample clock is intended to run at 10.48576 MHz. With a 20-bit accumulator, one increment step then equals exactly 10 Hz. The frequency is therefore programmed as a count of 10 Hz units, from 2 (20 Hz) up to 2000 (20 kHz), and that count is used directly as the increment. A new setting is captured only when the load strobe is high. Loading never clears the accumulator, so the phase runs on without a break.

Top module: `tdds_three_phase`

## Requirements
- R1: While `rst` is high at a clock edge, all three sample buses and `sample_valid` read 0 after that edge, the accumulator returns to phase 0 and the increment returns to 2.
- R2: On each clock edge after reset the accumulator adds the increment modulo 2^20. The sample produced at an edge is computed from the accumulator value held just before that edge, so the first sample after reset uses phase 0.
- R3: `freq_units` is captured as the new increment only at an edge where `freq_load` is high. The new increment is used for the first time at the following edge. Without a load, changes on `freq_units` have no effect.
- R4: A captured setting below 2 is replaced by 2, and a setting above 2000 is replaced by 2000.
- R5: Loading a new frequency does not disturb the accumulator: the phase keeps advancing from the value it had reached.
- R6: Channel 0 uses the accumulator phase as it is. Channel 1 adds 349525 and channel 2 adds 699051, both modulo 2^20. Each channel's lookup address is the top 8 bits of its own phase.
- R7: With `wave_sel` = 2'b00 or 2'b11, a channel outputs round(127.5 + 127.5*sin(2*pi*a/256)) for its address a, with ties rounded up. This gives 128 at a = 0, 255 at a = 64 and 0 at a = 192.
- R8: With `wave_sel` = 2'b01 (triangle), a channel takes the top 9 bits of its phase. If the highest of these bits is 0, the output is the lower 8 bits; if it is 1, the output is their bitwise inverse.
- R9: With `wave_sel` = 2'b10 (square), a channel outputs 255 when the top bit of its phase is 0 and 0 when that bit is 1. Only the values 0 and 255 ever appear.
- R10: `wave_sel` is sampled at each edge and chooses the shape of the sample produced at that same edge, independently of any frequency load in that cycle.
- R11: `sample_valid` is 1 after every edge at which `rst` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| freq_units | input | 12 | Frequency setting in 10 Hz units |
| freq_load | input | 1 | Capture strobe for `freq_units` |
| wave_sel | input | 2 | Shape: 00 sine, 01 triangle, 10 square, 11 sine |
| ch0_sample | output | 8 | Channel at 0 degrees |
| ch1_sample | output | 8 | Channel at 120 degrees |
| ch2_sample | output | 8 | Channel at 240 degrees |
| sample_valid | output | 1 | Samples are live |

## Verification
A frequency load and a change of waveform can land on the same clock edge. Once the shape is switched, the sample from that edge must take the new shape while it is still computed from the phase that the old increment produced. The new increment must then be used from the next edge onward. The bench provokes this by raising `freq_load` and changing `wave_sel` in the same cycle, both during a sweep and right after reset is released. A reference accumulator in the bench predicts every sample of all three channels, so a load applied one edge too early or a shape switched one edge too late shows up as a miscompare.

// File: rtl/tdds_pkg.sv
package tdds_pkg;

  typedef enum logic [1:0] {
    WAVE_SINE   = 2'b00,
    WAVE_TRI    = 2'b01,
    WAVE_SQUARE = 2'b10,
    WAVE_SINE_B = 2'b11
  } wave_e;

  // Clamp a frequency setting into [lo, hi]
  function automatic int clamp_setting(input int s, input int lo, input int hi);
    if (s < lo) return lo;
    if (s > hi) return hi;
    return s;
  endfunction

  // Rounded offset of k thirds of a cycle for a phase of pw bits
  function automatic longint third_offset(input int k, input int pw);
    longint full;
    full = longint'(1) << pw;
    return (2 * k * full + 3) / 6;
  endfunction

  // sin(2*pi*q/depth) for q in [0, depth/4], by odd power series
  function automatic real quarter_sin(input int q, input int depth);
    real x, term, sum;
    x    = real'(q) * 6.283185307179586 / real'(depth);
    term = x;
    sum  = x;
    for (int i = 1; i <= 9; i++) begin
      term = -term * x * x / real'((2 * i) * (2 * i + 1));
      sum  = sum + term;
    end
    return sum;
  endfunction

  // Quantized sine code for table index k; zeros and peaks exact by symmetry
  function automatic int sine_code(input int k, input int depth, input int sw);
    int  half_d, quar_d, top, code;
    real s, v, mid;
    half_d = depth / 2;
    quar_d = depth / 4;
    top    = (1 << sw) - 1;
    mid    = real'(top) / 2.0;
    if (k <= quar_d)                 s =  quarter_sin(k, depth);
    else if (k <= half_d)            s =  quarter_sin(half_d - k, depth);
    else if (k <= half_d + quar_d)   s = -quarter_sin(k - half_d, depth);
    else                             s = -quarter_sin(depth - k, depth);
    v    = mid + mid * s + 0.5;
    code = $rtoi(v);
    if (code > top) code = top;
    if (code < 0) code = 0;
    return code;
  endfunction

endpackage

// File: rtl/tdds_phase_acc.sv
module tdds_phase_acc
  import tdds_pkg::*;
#(
  parameter int PHASE_W  = 20,
  parameter int FREQ_W   = 12,
  parameter int FREQ_MIN = 2,
  parameter int FREQ_MAX = 2000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [FREQ_W-1:0]  freq_units,
  input  logic               freq_load,
  output logic [PHASE_W-1:0] phase
);

  localparam logic [FREQ_W-1:0] TUNE_RESET = FREQ_W'(FREQ_MIN);

  logic [FREQ_W-1:0]  tune;
  logic [FREQ_W-1:0]  tune_clamped;
  logic [PHASE_W-1:0] phase_next;

  assign tune_clamped = FREQ_W'(clamp_setting(int'(freq_units), FREQ_MIN, FREQ_MAX));
  assign phase_next   = phase + PHASE_W'(tune);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
      tune  <= TUNE_RESET;
    end else begin
      phase <= phase_next;
      if (freq_load) tune <= tune_clamped;
    end
  end

  // R1
  acc_reset_chk: assert property (@(posedge clk)
    rst |=> (phase == '0 && tune == TUNE_RESET));

  // R4
  tune_range_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(tune) >= FREQ_MIN && int'(tune) <= FREQ_MAX));

  // R3
  tune_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !freq_load |=> $stable(tune));

  // R5
  load_no_jump_chk: assert property (@(posedge clk) disable iff (rst)
    (freq_load && !$past(rst)) |=> (phase != $past(phase) || tune == '0));

endmodule

// File: rtl/tdds_channel.sv
module tdds_channel
  import tdds_pkg::*;
#(
  parameter int                 PHASE_W  = 20,
  parameter int                 ADDR_W   = 8,
  parameter int                 SAMPLE_W = 8,
  parameter logic [PHASE_W-1:0] OFFSET   = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [PHASE_W-1:0]  phase,
  input  logic [1:0]          wave_sel,
  output logic [SAMPLE_W-1:0] sample
);

  localparam int DEPTH = 1 << ADDR_W;

  function automatic logic [DEPTH*SAMPLE_W-1:0] build_rom();
    logic [DEPTH*SAMPLE_W-1:0] r;
    r = '0;
    for (int k = 0; k < DEPTH; k++)
      r[k*SAMPLE_W +: SAMPLE_W] = SAMPLE_W'(sine_code(k, DEPTH, SAMPLE_W));
    return r;
  endfunction

  localparam logic [DEPTH*SAMPLE_W-1:0] SINE_ROM = build_rom();

  logic [PHASE_W-1:0]  chan_phase;
  logic [ADDR_W-1:0]   lut_addr;
  logic [SAMPLE_W:0]   tri_bits;
  logic                upper_half;
  logic [SAMPLE_W-1:0] sine_val;
  logic [SAMPLE_W-1:0] tri_val;
  logic [SAMPLE_W-1:0] sq_val;
  logic [SAMPLE_W-1:0] shape_next;

  assign chan_phase = phase + OFFSET;
  assign lut_addr   = chan_phase[PHASE_W-1 -: ADDR_W];
  assign tri_bits   = chan_phase[PHASE_W-1 -: SAMPLE_W+1];
  assign upper_half = chan_phase[PHASE_W-1];
  assign sine_val   = SINE_ROM[int'(lut_addr)*SAMPLE_W +: SAMPLE_W];
  assign tri_val    = tri_bits[SAMPLE_W] ? ~tri_bits[SAMPLE_W-1:0] : tri_bits[SAMPLE_W-1:0];
  assign sq_val     = upper_half ? '0 : '1;

  always_comb begin
    unique case (wave_e'(wave_sel))
      WAVE_TRI:    shape_next = tri_val;
      WAVE_SQUARE: shape_next = sq_val;
      default:     shape_next = sine_val;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) sample <= '0;
    else     sample <= shape_next;
  end

  // R1
  sample_reset_chk: assert property (@(posedge clk)
    rst |=> (sample == '0));

  // R9
  sq_level_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wave_sel) == WAVE_SQUARE) |-> (sample == '0 || sample == '1));

  // R8
  tri_peak_chk: assert property (@(posedge clk) disable iff (rst)
    (wave_sel == WAVE_TRI && tri_bits == {1'b0, {SAMPLE_W{1'b1}}}) |=> (sample == '1));

endmodule

// File: rtl/tdds_three_phase.sv
module tdds_three_phase
  import tdds_pkg::*;
#(
  parameter int PHASE_W  = 20,
  parameter int ADDR_W   = 8,
  parameter int SAMPLE_W = 8,
  parameter int FREQ_W   = 12,
  parameter int FREQ_MIN = 2,
  parameter int FREQ_MAX = 2000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [FREQ_W-1:0]   freq_units,
  input  logic                freq_load,
  input  logic [1:0]          wave_sel,
  output logic [SAMPLE_W-1:0] ch0_sample,
  output logic [SAMPLE_W-1:0] ch1_sample,
  output logic [SAMPLE_W-1:0] ch2_sample,
  output logic                sample_valid
);

  localparam int N_CH = 3;

  logic [PHASE_W-1:0]  acc_phase;
  logic [SAMPLE_W-1:0] chan_out [N_CH];

  tdds_phase_acc #(
    .PHASE_W  (PHASE_W),
    .FREQ_W   (FREQ_W),
    .FREQ_MIN (FREQ_MIN),
    .FREQ_MAX (FREQ_MAX)
  ) acc_i (
    .clk        (clk),
    .rst        (rst),
    .freq_units (freq_units),
    .freq_load  (freq_load),
    .phase      (acc_phase)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_chan
    localparam logic [PHASE_W-1:0] OFF = PHASE_W'(third_offset(g, PHASE_W));
    tdds_channel #(
      .PHASE_W  (PHASE_W),
      .ADDR_W   (ADDR_W),
      .SAMPLE_W (SAMPLE_W),
      .OFFSET   (OFF)
    ) chan_i (
      .clk      (clk),
      .rst      (rst),
      .phase    (acc_phase),
      .wave_sel (wave_sel),
      .sample   (chan_out[g])
    );
  end

  assign ch0_sample = chan_out[0];
  assign ch1_sample = chan_out[1];
  assign ch2_sample = chan_out[2];

  always_ff @(posedge clk) begin
    if (rst) sample_valid <= 1'b0;
    else     sample_valid <= 1'b1;
  end

  // R11
  valid_live_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> sample_valid);

  // R11
  valid_reset_chk: assert property (@(posedge clk)
    rst |=> !sample_valid);

endmodule

// File: tb/tdds_three_phase_tb_top.sv
module tdds_three_phase_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int PW = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] freq_units = '0;
  logic        freq_load = 1'b0;
  logic [1:0]  wave_sel = 2'b00;
  logic [7:0]  ch0_sample, ch1_sample, ch2_sample;
  logic        sample_valid;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdds_three_phase dut_i (
    .clk          (clk),
    .rst          (rst),
    .freq_units   (freq_units),
    .freq_load    (freq_load),
    .wave_sel     (wave_sel),
    .ch0_sample   (ch0_sample),
    .ch1_sample   (ch1_sample),
    .ch2_sample   (ch2_sample),
    .sample_valid (sample_valid)
  );

  // Reference state, stepped at each rising edge from the requirements
  int unsigned m_acc = 0;
  int unsigned m_tune = 2;
  int unsigned m_phase = 0;
  logic [1:0]  m_sel = 2'b00;
  bit          m_live = 0;

  function automatic int unsigned ref_clamp(input int unsigned s);
    if (s < 2) return 2;
    if (s > 2000) return 2000;
    return s;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_acc = 0; m_tune = 2; m_live = 0;
    end else begin
      m_phase = m_acc;
      m_sel   = wave_sel;
      m_acc   = (m_acc + m_tune) % (1 << PW);
      if (freq_load) m_tune = ref_clamp(freq_units);
      m_live  = 1;
    end
  end

  function automatic int ref_sine(input int unsigned p);
    int  a;
    real v;
    a = int'(p >> 12);
    v = 127.5 + 127.5 * $sin(2.0 * 3.141592653589793 * real'(a) / 256.0);
    return $rtoi(v + 0.5);
  endfunction

  function automatic int ref_tri(input int unsigned p);
    int t;
    t = int'(p >> 11);
    if (t >= 256) return 255 - (t - 256);
    return t;
  endfunction

  function automatic int ref_square(input int unsigned p);
    return (p < (1 << (PW - 1))) ? 255 : 0;
  endfunction

  function automatic int ref_shape(input logic [1:0] sel, input int unsigned p);
    case (sel)
      2'b01:   return ref_tri(p);
      2'b10:   return ref_square(p);
      default: return ref_sine(p);
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp, input int tol);
    int d;
    n_vec++;
    d = act - exp;
    if (d < 0) d = -d;
    if (d > tol) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Compare all channels against the reference (R2 R6 R7 R8 R9 R10)
  task automatic chk_channels(input string req);
    int unsigned offs [3];
    int          acts [3];
    int          tol;
    offs[0] = 0; offs[1] = 349525; offs[2] = 699051;
    acts[0] = ch0_sample; acts[1] = ch1_sample; acts[2] = ch2_sample;
    tol = (m_sel == 2'b00 || m_sel == 2'b11) ? 1 : 0;
    for (int c = 0; c < 3; c++)
      chk(req, acts[c], ref_shape(m_sel, (m_phase + offs[c]) % (1 << PW)), tol);
    chk({req, " R11 valid"}, int'(sample_valid), 1, 0);
  endtask

  task automatic run_cycles(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk_channels(req);
    end
  endtask

  task automatic load_freq(input int unsigned f);
    freq_units = 12'(f);
    freq_load  = 1'b1;
    @(negedge clk);
    chk_channels("R3 load edge");
    freq_load  = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 ch0 in reset", ch0_sample, 0, 0);
    chk("R1 ch1 in reset", ch1_sample, 0, 0);
    chk("R1 ch2 in reset", ch2_sample, 0, 0);
    chk("R11 valid in reset", sample_valid, 0, 0);
  endtask

  task automatic t_release_triangle();
    wave_sel = 2'b01;
    rst = 1'b0;
    @(negedge clk);
    chk("R8 R6 ch0 first sample", ch0_sample, 0, 0);
    chk("R8 R6 ch1 first sample", ch1_sample, 170, 0);
    chk("R8 R6 ch2 first sample", ch2_sample, 170, 0);
    chk("R11 valid after release", sample_valid, 1, 0);
    run_cycles(40, "R2 triangle at reset rate");
  endtask

  task automatic t_sine_sweep();
    wave_sel = 2'b00;
    @(negedge clk);
    chk_channels("R10 R7 switch to sine");
    load_freq(2000);
    run_cycles(700, "R7 sine at 2000");
    wave_sel = 2'b11;
    run_cycles(300, "R7 sine alternate code");
  endtask

  task automatic t_square_period();
    int last_rise, cur, prev, rises, per;
    wave_sel = 2'b10;
    load_freq(1000);
    last_rise = -1; prev = ch0_sample; rises = 0;
    for (int i = 0; i < 3300; i++) begin
      @(negedge clk);
      chk_channels("R9 square at 1000");
      cur = ch0_sample;
      if (prev == 0 && cur == 255) begin
        if (last_rise >= 0) begin
          per = i - last_rise;
          chk("R9 R2 square period", per, (per == 1049) ? 1049 : 1048, 0);
        end
        last_rise = i;
        rises++;
      end
      prev = cur;
    end
    chk("R9 rising edges seen", (rises >= 2) ? 1 : 0, 1, 0);
  endtask

  task automatic t_clamp();
    wave_sel = 2'b01;
    load_freq(0);
    run_cycles(50, "R4 clamp low from 0");
    load_freq(1);
    run_cycles(50, "R4 clamp low from 1");
    load_freq(4000);
    run_cycles(300, "R4 clamp high from 4000");
    load_freq(2001);
    run_cycles(300, "R4 clamp high from 2001");
    // R3: setting moves without a strobe
    freq_units = 12'd37;
    run_cycles(200, "R3 no load, no change");
  endtask

  task automatic t_continuity_and_coincide();
    wave_sel = 2'b00;
    load_freq(731);
    run_cycles(500, "R5 before change");
    freq_units = 12'd1999;
    freq_load  = 1'b1;
    wave_sel   = 2'b10;
    @(negedge clk);
    chk_channels("R5 R10 load and shape in one cycle");
    freq_load  = 1'b0;
    run_cycles(400, "R5 phase continuous after change");
  endtask

  task automatic t_reset_midrun();
    rst = 1'b1;
    @(negedge clk);
    chk("R1 ch1 cleared", ch1_sample, 0, 0);
    chk("R11 valid cleared", sample_valid, 0, 0);
    wave_sel = 2'b10;
    rst = 1'b0;
    @(negedge clk);
    chk("R1 R9 ch0 restarts at phase 0", ch0_sample, 255, 0);
    chk("R1 R9 ch2 restarts at phase 0", ch2_sample, 0, 0);
    run_cycles(100, "R1 increment back to 2");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_release_triangle();
    t_sine_sweep();
    t_square_period();
    t_clamp();
    t_continuity_and_coincide();
    t_reset_midrun();
    finish_run();
  end

endmodule